// File: doc/BRIEF.md
# Non-Volatile Memory Write-Lock Controller

This block sits in front of a non-volatile memory and decides, for every write or erase request, whether it may reach the array. It guards two regions, a program region and a data region. Each region has its own key register, and it opens only after two specific key bytes are written to that register in a fixed order. Any wrong key byte seals that region until the next reset. Software can close an open region again through a relock register. The usual practice is to relock right after a write completes.

The first pages of the program region form a boot-code area. Its size is set by the `boot_pages` input, counted in pages of `PAGE_BYTES` from the start of the program region. No key sequence makes that area writable. Each request gets its verdict one cycle later. An accepted request pulses the write enable of its region together with `wr_accept`. A refused request pulses `wr_reject` and sets a sticky illegal-attempt flag. The array and its programming timing are outside this block.

Top module: `nvm_wlock`

## Requirements
- R1: After reset both regions are locked, `prog_wen`, `data_wen`, `wr_accept`, `wr_reject` and `illegal_flag` are low, and any memory write is rejected.
- R2: Writing 0x56 and then 0xAE to register address 0 opens the program region. Writes to other register addresses between the two keys do not disturb the sequence. While the region is open, further writes to address 0 leave it open.
- R3: Writing 0xAE and then 0x56 to register address 1 opens the data region. The program key order written to address 1 does not open it.
- R4: A wrong first or second key byte locks that region until the next reset, even if the correct sequence follows. The other region is unaffected.
- R5: A write to register address 2 with bit 0 set relocks the program region, and one with bit 1 set relocks the data region. A relocked region that is not sealed can be reopened with its key sequence.
- R6: A program-region address whose offset from the region start is below `boot_pages`*64 is rejected even when the region is open. When `boot_pages` is 0, no part of the region is protected.
- R7: One cycle after `mem_wr`, exactly one outcome appears. It is either `prog_wen` (for 0x8000–0xFFFF) or `data_wen` (for 0x4000–0x47FF), each together with `wr_accept`, or it is `wr_reject`. Addresses outside both regions are always rejected.
- R8: `illegal_flag` rises together with the first `wr_reject` and stays high until reset. Rejected requests raise no write enable.
- R9: A memory request in the same cycle as a register write is judged on the lock state from before that register write. Writes to register address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 program key, 1 data key, 2 relock) |
| reg_wdata | input | 8 | Register write data |
| mem_wr | input | 1 | Memory write/erase request |
| mem_addr | input | 16 | Target byte address of the request |
| boot_pages | input | 4 | Number of protected boot-code pages |
| prog_wen | output | 1 | Program-region write enable pulse |
| data_wen | output | 1 | Data-region write enable pulse |
| wr_accept | output | 1 | Request accepted strobe |
| wr_reject | output | 1 | Request rejected strobe |
| illegal_flag | output | 1 | Sticky illegal write attempt flag |

## Verification
Directed sequences try the correct key order, the reversed order, a wrong first byte and a wrong second byte. Together these separate an opened region from a sealed one and a sealed one from a merely relocked one. Addresses are drawn around the boot-page boundary with `boot_pages` at zero and non-zero, so the protected area is shown to be independent of the key state. Random streams mix key writes, relocks, stray register writes and requests to both regions and to unmapped space, often in the same cycle. This tells apart a controller that judges on the old lock state from one that judges on the new one.

// File: rtl/nvm_wlock_pkg.sv
package nvm_wlock_pkg;
   typedef enum logic [1:0] {
      KS_LOCKED = 2'd0,
      KS_HALF   = 2'd1,
      KS_OPEN   = 2'd2,
      KS_SEALED = 2'd3
   } key_st_e;
endpackage

// File: rtl/nvm_key_seq.sv
module nvm_key_seq
   import nvm_wlock_pkg::*;
#(
   parameter int unsigned KEY_W = 8,
   parameter logic [KEY_W-1:0] KEY_A = 8'h56,
   parameter logic [KEY_W-1:0] KEY_B = 8'hAE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_wr,
   input  logic [KEY_W-1:0] key_data,
   input  logic             relock,
   output key_st_e          state
);
   key_st_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         KS_LOCKED: if (key_wr) nxt = (key_data == KEY_A) ? KS_HALF : KS_SEALED;
         KS_HALF: begin
            if (relock)      nxt = KS_LOCKED;
            else if (key_wr) nxt = (key_data == KEY_B) ? KS_OPEN : KS_SEALED;
         end
         KS_OPEN:   if (relock) nxt = KS_LOCKED;
         KS_SEALED: nxt = KS_SEALED;
         default:   nxt = KS_SEALED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= KS_LOCKED;
      else        state <= nxt;
   end
endmodule

// File: rtl/nvm_region_dec.sv
module nvm_region_dec #(
   parameter int unsigned ADDR_W = 16,
   parameter longint unsigned BASE = 64'h8000,
   parameter longint unsigned SIZE = 64'h8000
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [ADDR_W-1:0] offset
);
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);
   localparam logic [ADDR_W:0]   SIZE_V = (ADDR_W+1)'(SIZE);

   always_comb begin
      offset = addr - BASE_V;
      hit    = (addr >= BASE_V) && ({1'b0, offset} < SIZE_V);
   end
endmodule

// File: rtl/nvm_wlock.sv
module nvm_wlock
   import nvm_wlock_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned REG_AW     = 2,
   parameter int unsigned KEY_W      = 8,
   parameter longint unsigned PROG_BASE = 64'h8000,
   parameter longint unsigned PROG_SIZE = 64'h8000,
   parameter longint unsigned DATA_BASE = 64'h4000,
   parameter longint unsigned DATA_SIZE = 64'h0800,
   parameter int unsigned PAGE_BYTES = 64,
   parameter int unsigned BOOT_PG_W  = 4,
   parameter int unsigned PKEY_REG   = 0,
   parameter int unsigned DKEY_REG   = 1,
   parameter int unsigned RELOCK_REG = 2,
   parameter logic [KEY_W-1:0] PKEY1 = 8'h56,
   parameter logic [KEY_W-1:0] PKEY2 = 8'hAE,
   parameter logic [KEY_W-1:0] DKEY1 = 8'hAE,
   parameter logic [KEY_W-1:0] DKEY2 = 8'h56
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [REG_AW-1:0]    reg_addr,
   input  logic [KEY_W-1:0]     reg_wdata,
   input  logic                 mem_wr,
   input  logic [ADDR_W-1:0]    mem_addr,
   input  logic [BOOT_PG_W-1:0] boot_pages,
   output logic                 prog_wen,
   output logic                 data_wen,
   output logic                 wr_accept,
   output logic                 wr_reject,
   output logic                 illegal_flag
);
   localparam int unsigned PG_SH = $clog2(PAGE_BYTES);
   localparam int unsigned LIM_W = BOOT_PG_W + PG_SH;
   localparam int unsigned NREG  = 2;

   // elaboration-time parameter checks
   if (PAGE_BYTES != (1 << PG_SH)) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if (LIM_W > ADDR_W) begin : g_bad_boot
      $error("boot area limit wider than address");
   end
   if (PROG_BASE + PROG_SIZE > (64'd1 << ADDR_W) ||
       DATA_BASE + DATA_SIZE > (64'd1 << ADDR_W)) begin : g_bad_map
      $error("region exceeds address space");
   end
   if (!(PROG_BASE >= DATA_BASE + DATA_SIZE || DATA_BASE >= PROG_BASE + PROG_SIZE)) begin : g_bad_ovl
      $error("regions overlap");
   end
   if (PKEY_REG == DKEY_REG || PKEY_REG == RELOCK_REG || DKEY_REG == RELOCK_REG) begin : g_bad_reg
      $error("register addresses must differ");
   end
   if (KEY_W < NREG) begin : g_bad_kw
      $error("data width too small for relock bits");
   end

   key_st_e           ks  [NREG];
   logic              hit [NREG];
   logic [ADDR_W-1:0] off [NREG];
   key_st_e           p_st, d_st;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam logic [KEY_W-1:0] KA = (g == 0) ? PKEY1 : DKEY1;
      localparam logic [KEY_W-1:0] KB = (g == 0) ? PKEY2 : DKEY2;
      localparam int unsigned      KR = (g == 0) ? PKEY_REG : DKEY_REG;
      localparam longint unsigned  RB = (g == 0) ? PROG_BASE : DATA_BASE;
      localparam longint unsigned  RS = (g == 0) ? PROG_SIZE : DATA_SIZE;

      logic key_hit, relock_hit;
      assign key_hit    = reg_wr && (reg_addr == REG_AW'(KR));
      assign relock_hit = reg_wr && (reg_addr == REG_AW'(RELOCK_REG)) && reg_wdata[g];

      nvm_key_seq #(.KEY_W(KEY_W), .KEY_A(KA), .KEY_B(KB)) u_seq (
         .clk      (clk),
         .rst_n    (rst_n),
         .key_wr   (key_hit),
         .key_data (reg_wdata),
         .relock   (relock_hit),
         .state    (ks[g])
      );

      nvm_region_dec #(.ADDR_W(ADDR_W), .BASE(RB), .SIZE(RS)) u_dec (
         .addr   (mem_addr),
         .hit    (hit[g]),
         .offset (off[g])
      );
   end

   assign p_st = ks[0];
   assign d_st = ks[1];

   logic [ADDR_W-1:0] boot_lim;
   logic              in_boot, pass_p, pass_d;

   always_comb begin
      boot_lim = ADDR_W'(boot_pages) << PG_SH;
      in_boot  = hit[0] && (off[0] < boot_lim);
      pass_p   = mem_wr && hit[0] && !in_boot && (ks[0] == KS_OPEN);
      pass_d   = mem_wr && hit[1] && (ks[1] == KS_OPEN);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_wen     <= 1'b0;
         data_wen     <= 1'b0;
         wr_accept    <= 1'b0;
         wr_reject    <= 1'b0;
         illegal_flag <= 1'b0;
      end else begin
         prog_wen  <= pass_p;
         data_wen  <= pass_d;
         wr_accept <= pass_p || pass_d;
         wr_reject <= mem_wr && !pass_p && !pass_d;
         if (mem_wr && !pass_p && !pass_d) illegal_flag <= 1'b1;
      end
   end
endmodule

// File: rtl/nvm_wlock_chk.sv
module nvm_wlock_chk
   import nvm_wlock_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned BOOT_PG_W  = 4,
   parameter longint unsigned PROG_BASE = 64'h8000,
   parameter int unsigned PAGE_BYTES = 64
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 mem_wr,
   input logic [ADDR_W-1:0]    mem_addr,
   input logic [BOOT_PG_W-1:0] boot_pages,
   input logic                 prog_wen,
   input logic                 data_wen,
   input logic                 wr_accept,
   input logic                 wr_reject,
   input logic                 illegal_flag,
   input key_st_e              p_st,
   input key_st_e              d_st
);
   localparam int unsigned PG_SH = $clog2(PAGE_BYTES);

   logic [ADDR_W-1:0] off_q, lim_q;
   logic              req_q, popen_q, dopen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q <= '0; lim_q <= '0; req_q <= 1'b0; popen_q <= 1'b0; dopen_q <= 1'b0;
      end else begin
         off_q   <= mem_addr - ADDR_W'(PROG_BASE);
         lim_q   <= ADDR_W'(boot_pages) << PG_SH;
         req_q   <= mem_wr;
         popen_q <= (p_st == KS_OPEN);
         dopen_q <= (d_st == KS_OPEN);
      end
   end

   // R7: one outcome per request, none without one
   a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog_wen, data_wen, wr_reject}) && ((prog_wen || data_wen || wr_reject) == req_q));
   // R6: boot area never written
   a_r6_boot_safe: assert property (@(posedge clk) disable iff (!rst_n)
      prog_wen |-> (off_q >= lim_q));
   // R2: program write only while program region was open
   a_r2_prog_open: assert property (@(posedge clk) disable iff (!rst_n)
      prog_wen |-> popen_q);
   // R3: data write only while data region was open
   a_r3_data_open: assert property (@(posedge clk) disable iff (!rst_n)
      data_wen |-> dopen_q);
   // R4: a sealed region stays sealed
   a_r4_sealed_p: assert property (@(posedge clk) disable iff (!rst_n)
      (p_st == KS_SEALED) |=> (p_st == KS_SEALED));
   a_r4_sealed_d: assert property (@(posedge clk) disable iff (!rst_n)
      (d_st == KS_SEALED) |=> (d_st == KS_SEALED));
   // R8: flag is sticky and accompanies every reject
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_flag |=> illegal_flag);
   a_r8_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reject |-> illegal_flag);
   // R7: accept strobe matches enables
   a_r7_accept: assert property (@(posedge clk) disable iff (!rst_n)
      wr_accept |-> (prog_wen || data_wen));
endmodule

bind nvm_wlock nvm_wlock_chk #(
   .ADDR_W(ADDR_W), .BOOT_PG_W(BOOT_PG_W), .PROG_BASE(PROG_BASE), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_wr(mem_wr), .mem_addr(mem_addr), .boot_pages(boot_pages),
   .prog_wen(prog_wen), .data_wen(data_wen), .wr_accept(wr_accept), .wr_reject(wr_reject),
   .illegal_flag(illegal_flag), .p_st(p_st), .d_st(d_st)
);

// File: tb/nvm_wlock_bench.sv
module nvm_wlock_bench;
   localparam int PB = 'h8000, PS = 'h8000, DB = 'h4000, DS = 'h0800, PG = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic        mem_wr = 1'b0;
   logic [15:0] mem_addr = '0;
   logic [3:0]  boot_pages = '0;
   logic        prog_wen, data_wen, wr_accept, wr_reject, illegal_flag;

   nvm_wlock u_nvm_wlock (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .mem_wr(mem_wr), .mem_addr(mem_addr), .boot_pages(boot_pages),
      .prog_wen(prog_wen), .data_wen(data_wen), .wr_accept(wr_accept),
      .wr_reject(wr_reject), .illegal_flag(illegal_flag)
   );

   always #10 clk = ~clk;

   int checks = 0, fails = 0, cycles = 0;
   bit done = 0;
   // model: 0 locked, 1 half, 2 open, 3 sealed
   int m_p = 0, m_d = 0;
   bit m_ill = 0;

   function automatic int key_next(int st, bit wr, logic [7:0] d, logic [7:0] k1, logic [7:0] k2, bit rl);
      if (st == 3) return 3;
      if (rl && (st == 1 || st == 2)) return 0;
      if (!wr) return st;
      if (st == 0) return (d == k1) ? 1 : 3;
      if (st == 1) return (d == k2) ? 2 : 3;
      return st;
   endfunction

   function automatic bit in_prog(int a); return a >= PB && a < PB + PS; endfunction
   function automatic bit in_data(int a); return a >= DB && a < DB + DS; endfunction
   function automatic bit in_boot(int a, int bp); return in_prog(a) && (a - PB) < bp * PG; endfunction

   task automatic chk(string tag, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // one cycle: inputs already set before the call (at negedge)
   task automatic step(string tag);
      bit pw, dw, rj, rlp, rld, kp, kd;
      int a;
      string t;
      a  = int'(mem_addr);
      pw = mem_wr && in_prog(a) && !in_boot(a, int'(boot_pages)) && m_p == 2;
      dw = mem_wr && in_data(a) && m_d == 2;
      rj = mem_wr && !pw && !dw;
      kp  = reg_wr && reg_addr == 2'd0;
      kd  = reg_wr && reg_addr == 2'd1;
      rlp = reg_wr && reg_addr == 2'd2 && reg_wdata[0];
      rld = reg_wr && reg_addr == 2'd2 && reg_wdata[1];
      m_p = key_next(m_p, kp, reg_wdata, 8'h56, 8'hAE, rlp);
      m_d = key_next(m_d, kd, reg_wdata, 8'hAE, 8'h56, rld);
      m_ill = m_ill | rj;
      if (tag != "") t = tag;
      else if (in_boot(a, int'(boot_pages))) t = "R6";
      else if (in_data(a)) t = "R3";
      else if (in_prog(a)) t = "R2";
      else t = "R7";
      @(posedge clk); #1;
      chk(t, "prog_wen", prog_wen, pw);
      chk(t, "data_wen", data_wen, dw);
      chk("R7", "wr_accept", wr_accept, pw | dw);
      chk(t, "wr_reject", wr_reject, rj);
      chk("R8", "illegal_flag", illegal_flag, m_ill);
      @(negedge clk);
      reg_wr = 0; mem_wr = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; reg_wr = 0; mem_wr = 0;
      repeat (2) @(negedge clk);
      m_p = 0; m_d = 0; m_ill = 0;
      chk("R1", "prog_wen", prog_wen, 0);
      chk("R1", "wr_reject", wr_reject, 0);
      chk("R1", "illegal_flag", illegal_flag, 0);
      rst_n = 1;
   endtask

   task automatic rw(logic [1:0] ad, logic [7:0] d, string tag);
      reg_wr = 1; reg_addr = ad; reg_wdata = d; step(tag);
   endtask
   task automatic mw(int a, string tag);
      mem_wr = 1; mem_addr = 16'(a); step(tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   initial begin
      while (cycles < 100000) begin @(posedge clk); cycles++; end
      fails++; checks++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      void'($urandom(32'd1234));
      do_reset();
      // R1: locked after reset
      mw('h9000, "R1"); mw('h4010, "R1");
      // R2: program unlock with stray register write in between, then open-state key write
      do_reset();
      rw(0, 8'h56, "R2"); rw(3, 8'h11, "R9"); rw(0, 8'hAE, "R2");
      mw('h9000, "R2"); rw(0, 8'h00, "R2"); mw('h9002, "R2");
      // R6: boot area
      boot_pages = 4'd2;
      mw('h8040, "R6"); mw('h807F, "R6"); mw('h8080, "R6");
      boot_pages = 4'd0;
      mw('h8000, "R6");
      // R7: unmapped address
      mw('h0100, "R7"); mw('h4800, "R7");
      // R3: program order at data register seals data; data order works after reset
      rw(1, 8'h56, "R3"); rw(1, 8'hAE, "R3"); mw('h4010, "R3");
      do_reset();
      rw(1, 8'hAE, "R3"); rw(1, 8'h56, "R3"); mw('h4010, "R3"); mw('h9000, "R3");
      // R5: relock program only, reopen
      rw(0, 8'h56, "R5"); rw(0, 8'hAE, "R5");
      rw(2, 8'h01, "R5"); mw('h9000, "R5"); mw('h47FF, "R5");
      rw(0, 8'h56, "R5"); rw(0, 8'hAE, "R5"); mw('h9000, "R5");
      rw(2, 8'h02, "R5"); mw('h4000, "R5");
      // R4: wrong first key, then correct sequence
      do_reset();
      rw(0, 8'h11, "R4"); rw(0, 8'h56, "R4"); rw(0, 8'hAE, "R4"); mw('h9000, "R4");
      rw(1, 8'hAE, "R4"); rw(1, 8'h56, "R4"); mw('h4000, "R4");
      rw(2, 8'h03, "R4"); rw(0, 8'h56, "R4"); rw(0, 8'hAE, "R4"); mw('h9000, "R4");
      // R4: wrong second key
      rw(1, 8'hAE, "R4"); rw(1, 8'h00, "R4"); rw(1, 8'hAE, "R4"); rw(1, 8'h56, "R4"); mw('h4000, "R4");
      // R9: request in same cycle as completing key
      do_reset();
      rw(0, 8'h56, "R9");
      reg_wr = 1; reg_addr = 0; reg_wdata = 8'hAE; mem_wr = 1; mem_addr = 16'h9000; step("R9");
      reg_wr = 1; reg_addr = 2; reg_wdata = 8'h01; mem_wr = 1; mem_addr = 16'h9004; step("R9");
      mw('h9004, "R9");

      // random phase
      for (int i = 0; i < 4000; i++) begin
         int r;
         if (i % 250 == 0) do_reset();
         r = int'($urandom % 100);
         if (r < 45) begin
            reg_wr = 1;
            reg_addr = 2'($urandom % 4);
            if ($urandom % 100 < 85) begin
               if (reg_addr == 0)      reg_wdata = (m_p == 1) ? 8'hAE : 8'h56;
               else if (reg_addr == 1) reg_wdata = (m_d == 1) ? 8'h56 : 8'hAE;
               else                    reg_wdata = ($urandom % 4 == 0) ? 8'($urandom % 4) : 8'h00;
            end else reg_wdata = 8'($urandom);
         end
         if ($urandom % 100 < 60) begin
            int s;
            mem_wr = 1;
            s = int'($urandom % 4);
            if (s == 0)      mem_addr = 16'(PB + int'($urandom % 1024));
            else if (s == 1) mem_addr = 16'(PB + int'($urandom % PS));
            else if (s == 2) mem_addr = 16'(DB + int'($urandom % DS));
            else             mem_addr = 16'($urandom % 'h8000);
         end
         if ($urandom % 50 == 0) boot_pages = 4'($urandom);
         step("");
      end
      finish_run();
   end
endmodule